// File: doc/BRIEF.md
# Shared-Bus Register Transfer Datapath with Word Memory

This block is a small register-transfer datapath. Four registers of `DATA_W` bits share one bus. A two-bit source code steers a 4-to-1 multiplexer on every bus bit, so the chosen register appears on the bus. A separate two-bit destination code, qualified by a load enable, goes through a 2-to-4 decoder. The decoder picks the single register that captures the bus on the next rising clock edge. The source and destination choices are independent. A transfer therefore copies one register into another in a single edge and leaves the source intact.

Two of the four registers also serve a word memory of `2**ADDR_W` entries. Register index 2 acts as the address register and register index 3 acts as the data register. A read command loads the addressed word into the data register. A write command stores the data register into the addressed word. An external constant can be driven onto the bus in place of the multiplexer output, which is how values enter the datapath.

Top module: `xfer_bus_top`

## Requirements
- R1: An active-high reset, sampled on the rising clock edge, clears all four registers to zero.
- R2: While `const_en` is 0, `bus_o` equals the register selected by `src_sel`, where code 0 selects register 0, code 1 selects register 1, code 2 selects register 2 (address) and code 3 selects register 3 (data).
- R3: While `const_en` is 1, `bus_o` equals `ext_data`, whatever `src_sel` holds.
- R4: With `load_en` at 1, the register numbered `dst_sel` takes the bus value at the rising edge. All bits move on that one edge, and no other register is changed by the bus.
- R5: With `load_en` at 0 and no memory read taking effect, no register changes at the clock edge.
- R6: A transfer leaves its source register unchanged. When source and destination are the same register, that register keeps its value.
- R7: `mem_rd` at 1 with `mem_wr` at 0 loads register 3 with the memory word addressed by register 2 at the rising edge. This read takes priority over a bus load aimed at register 3 in the same cycle.
- R8: `mem_wr` at 1 stores the pre-edge value of register 3 into the memory word addressed by the pre-edge value of register 2.
- R9: When `mem_rd` and `mem_wr` are both 1, the write is performed and the read is ignored, so register 3 changes only through a bus load.
- R10: The memory holds `2**ADDR_W` words and is addressed by the low `ADDR_W` bits of register 2. Higher address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Source register code for the bus |
| const_en | input | 1 | Drive `ext_data` onto the bus instead of a register |
| ext_data | input | DATA_W | External constant for the bus |
| load_en | input | 1 | Enables the destination decoder |
| dst_sel | input | 2 | Destination register code |
| mem_rd | input | 1 | Memory read into register 3 |
| mem_wr | input | 1 | Memory write from register 3 |
| bus_o | output | DATA_W | Current bus value |

## Verification
The registers are first filled with distinct constants and read back through every source code. This separates a swapped or stuck select line from a correct multiplexer. Register-to-register moves are tried with differing codes, with the same code for source and destination, and with the enable low. These cases tell a wrong decoder or a disturbed source apart from a correct load. Memory writes and reads are run over all addresses with varying data, including a read that collides with a bus load to the data register and a cycle with both commands. An address whose upper bits differ tests that only the low bits select the word.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    localparam int NREG  = 4;
    localparam int SEL_W = $clog2(NREG);
    localparam int AR_IDX = 2;
    localparam int DR_IDX = 3;

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [NREG-1:0]  onehot_t;

    typedef enum logic [1:0] {
        MEM_IDLE  = 2'd0,
        MEM_READ  = 2'd1,
        MEM_WRITE = 2'd2
    } mem_cmd_e;

    // Write wins over read when both are requested.
    function automatic mem_cmd_e resolve_cmd(input logic rd, input logic wr);
        if (wr)      return MEM_WRITE;
        else if (rd) return MEM_READ;
        else         return MEM_IDLE;
    endfunction

    function automatic onehot_t decode_sel(input logic en, input sel_t sel);
        onehot_t v;
        v = '0;
        if (en) v[sel] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/xfer_bus_mux.sv
module xfer_bus_mux
    import xfer_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] regs_i [NREG],
    input  sel_t              src_sel,
    input  logic              const_en,
    input  logic [DATA_W-1:0] ext_data,
    output logic [DATA_W-1:0] bus_o
);

    logic [DATA_W-1:0] mux_out;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        always_comb begin
            case (src_sel)
                2'd0:    mux_out[b] = regs_i[0][b];
                2'd1:    mux_out[b] = regs_i[1][b];
                2'd2:    mux_out[b] = regs_i[2][b];
                default: mux_out[b] = regs_i[3][b];
            endcase
        end
    end

    assign bus_o = const_en ? ext_data : mux_out;

endmodule

// File: rtl/xfer_dest_dec.sv
module xfer_dest_dec
    import xfer_pkg::*;
(
    input  logic    en,
    input  sel_t    sel,
    output onehot_t load_o
);

    always_comb load_o = decode_sel(en, sel);

endmodule

// File: rtl/xfer_word_mem.sv
module xfer_word_mem #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) words[addr] <= wdata;
    end

    assign rdata = words[addr];

endmodule

// File: rtl/xfer_bus_top.sv
module xfer_bus_top
    import xfer_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        src_sel,
    input  logic              const_en,
    input  logic [DATA_W-1:0] ext_data,
    input  logic              load_en,
    input  logic [1:0]        dst_sel,
    input  logic              mem_rd,
    input  logic              mem_wr,
    output logic [DATA_W-1:0] bus_o
);

    logic [DATA_W-1:0] regs_q [NREG];
    logic [DATA_W-1:0] bus_w;
    logic [DATA_W-1:0] mem_rdata;
    onehot_t           load_vec;
    mem_cmd_e          cmd;

    assign cmd = resolve_cmd(mem_rd, mem_wr);

    xfer_bus_mux #(.DATA_W(DATA_W)) u_mux (
        .regs_i   (regs_q),
        .src_sel  (src_sel),
        .const_en (const_en),
        .ext_data (ext_data),
        .bus_o    (bus_w)
    );

    xfer_dest_dec u_dec (
        .en     (load_en),
        .sel    (dst_sel),
        .load_o (load_vec)
    );

    xfer_word_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (cmd == MEM_WRITE),
        .addr  (regs_q[AR_IDX][ADDR_W-1:0]),
        .wdata (regs_q[DR_IDX]),
        .rdata (mem_rdata)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == DR_IDX) begin : g_dr
            always_ff @(posedge clk) begin
                if (rst)                    regs_q[g] <= '0;
                else if (cmd == MEM_READ)   regs_q[g] <= mem_rdata;
                else if (load_vec[g])       regs_q[g] <= bus_w;
            end
        end else begin : g_gp
            always_ff @(posedge clk) begin
                if (rst)               regs_q[g] <= '0;
                else if (load_vec[g])  regs_q[g] <= bus_w;
            end
        end
    end

    assign bus_o = bus_w;

endmodule

// File: rtl/xfer_bus_chk.sv
module xfer_bus_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        src_sel,
    input logic              load_en,
    input logic [1:0]        dst_sel,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [DATA_W-1:0] bus_o,
    input logic [DATA_W-1:0] regs [4]
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (regs[0] == '0 && regs[1] == '0 && regs[2] == '0 && regs[3] == '0));

    // R4
    dest_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (load_en && dst_sel != 2'd3) |=> regs[$past(dst_sel)] == $past(bus_o));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !(mem_rd && !mem_wr)) |=>
            ($stable(regs[0]) && $stable(regs[1]) && $stable(regs[2]) && $stable(regs[3])));

    // R6
    source_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (load_en && src_sel != dst_sel && src_sel != 2'd3) |=>
            regs[$past(src_sel)] == $past(regs[src_sel]));

    // R9
    read_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && mem_wr && !(load_en && dst_sel == 2'd3)) |=> $stable(regs[3]));

endmodule

bind xfer_bus_top xfer_bus_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .src_sel (src_sel),
    .load_en (load_en),
    .dst_sel (dst_sel),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .bus_o   (bus_o),
    .regs    (regs_q)
);

// File: tb/xfer_bus_top_test.sv
module xfer_bus_top_test;

    localparam int W  = 8;
    localparam int AW = 4;
    localparam int D  = 1 << AW;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   src_sel, dst_sel;
    logic         const_en, load_en, mem_rd, mem_wr;
    logic [W-1:0] ext_data;
    logic [W-1:0] bus_o;

    logic [W-1:0] m_reg [4];
    logic [W-1:0] m_mem [D];
    int vec = 0;
    int bad = 0;

    always #2 clk = ~clk;

    xfer_bus_top #(.DATA_W(W), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .src_sel(src_sel), .const_en(const_en),
        .ext_data(ext_data), .load_en(load_en), .dst_sel(dst_sel),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .bus_o(bus_o)
    );

    task automatic step(input string tag, input logic cst, input logic [W-1:0] dat,
                        input logic [1:0] src, input logic ld, input logic [1:0] dst,
                        input logic rd, input logic wr);
        logic [W-1:0] exp_bus;
        logic [W-1:0] old_ar, old_dr;
        const_en = cst; ext_data = dat; src_sel = src;
        load_en = ld; dst_sel = dst; mem_rd = rd; mem_wr = wr;
        #1;
        exp_bus = cst ? dat : m_reg[src];
        if (!rst) begin
            vec++;
            if (bus_o !== exp_bus) begin
                bad++;
                $display("FAIL %s: bus_o=%h expected %h", tag, bus_o, exp_bus);
            end
        end
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < 4; i++) m_reg[i] = '0;
        end else begin
            old_ar = m_reg[2];
            old_dr = m_reg[3];
            if (ld) m_reg[dst] = exp_bus;
            if (wr) m_mem[old_ar[AW-1:0]] = old_dr;
            else if (rd) m_reg[3] = m_mem[old_ar[AW-1:0]];
        end
        @(negedge clk);
    endtask

    task automatic peek(input string tag, input logic [1:0] idx);
        step(tag, 1'b0, '0, idx, 1'b0, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic put(input string tag, input logic [W-1:0] v, input logic [1:0] dst);
        step(tag, 1'b1, v, 2'd0, 1'b1, dst, 1'b0, 1'b0);
    endtask

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        step("R1 reset", 1'b0, '0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0);
        step("R1 reset", 1'b0, '0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) peek("R1 cleared register", 2'(i));

        // R3 / R4: load distinct constants
        put("R3 const to r0", 8'h11, 2'd0);
        put("R3 const to r1", 8'h22, 2'd1);
        put("R3 const to r2", 8'h33, 2'd2);
        put("R3 const to r3", 8'h44, 2'd3);
        for (int i = 0; i < 4; i++) peek("R2 select readback", 2'(i));
        step("R3 const overrides src", 1'b1, 8'h9C, 2'd2, 1'b0, 2'd0, 1'b0, 1'b0);

        // R5: enable low, nothing loads
        step("R5 no load", 1'b1, 8'hEE, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) peek("R5 unchanged", 2'(i));

        // R4 / R6: register moves
        step("R4 move r0->r1", 1'b0, '0, 2'd0, 1'b1, 2'd1, 1'b0, 1'b0);
        peek("R6 source r0 kept", 2'd0);
        peek("R4 dest r1 loaded", 2'd1);
        step("R4 move r3->r0", 1'b0, '0, 2'd3, 1'b1, 2'd0, 1'b0, 1'b0);
        peek("R4 dest r0 loaded", 2'd0);
        step("R6 self r2->r2", 1'b0, '0, 2'd2, 1'b1, 2'd2, 1'b0, 1'b0);
        peek("R6 self unchanged", 2'd2);

        // R8 / R7 across every address
        for (int a = 0; a < D; a++) begin
            put("R8 set address", 8'(a), 2'd2);
            put("R8 set data", 8'(a * 37 + 5), 2'd3);
            step("R8 write", 1'b0, '0, 2'd1, 1'b0, 2'd0, 1'b0, 1'b1);
        end
        for (int a = D - 1; a >= 0; a--) begin
            put("R7 set address", 8'(a), 2'd2);
            step("R7 read", 1'b0, '0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b0);
            peek("R7 data after read", 2'd3);
        end

        // R7: read beats bus load into r3
        put("R7 set address", 8'd6, 2'd2);
        step("R7 read vs load", 1'b1, 8'hFF, 2'd0, 1'b1, 2'd3, 1'b1, 1'b0);
        peek("R7 read won", 2'd3);

        // R9: both asserted
        put("R9 set address", 8'd9, 2'd2);
        put("R9 set data", 8'h3C, 2'd3);
        step("R9 rd+wr", 1'b0, '0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1);
        peek("R9 data kept", 2'd3);
        put("R9 clear data", 8'h00, 2'd3);
        step("R9 read back", 1'b0, '0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b0);
        peek("R9 write happened", 2'd3);

        // R10: upper address bits ignored
        put("R10 aliased address", 8'hF9, 2'd2);
        step("R10 read alias", 1'b0, '0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b0);
        peek("R10 alias data", 2'd3);
        put("R10 data", 8'h5A, 2'd3);
        step("R10 write alias", 1'b0, '0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1);
        put("R10 plain address", 8'h09, 2'd2);
        step("R10 read plain", 1'b0, '0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b0);
        peek("R10 plain data", 2'd3);

        // R1: reset again mid-run
        rst = 1'b1;
        step("R1 reset", 1'b0, '0, 2'd0, 1'b1, 2'd1, 1'b0, 1'b0);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) peek("R1 cleared again", 2'(i));

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule